// File: doc/BRIEF.md
# SPI Word Slave with Host Registers

This block is the target side of a serial peripheral link. A local host processor reaches it through four memory-mapped registers. The host places an outgoing word in a transmit holding register and collects incoming words from a receive register. A status register and two maskable interrupt lines tell the host when a fresh word has landed and when the transmit holding register can take another word.

The serial side never starts a transfer. It stays idle until an external master pulls the active-low select low. From that point it drives the transmit word out on miso, most significant bit first, and at the same time collects mosi bits. The clock idles low. mosi is sampled on rising sclk edges, and miso changes on falling sclk edges. One select assertion carries exactly one word. The master must raise select and lower it again for the next word. A separate enable output follows the select pin, so a tri-state buffer can release miso on a shared bus.

The serial inputs are brought into the system clock domain through flop synchronizers. Edges are found on the synchronized clock, so the system clock must run at least four times faster than sclk. When the master lowers select, it must allow a few system clocks before the first rising sclk edge.

Top module: `spi_word_slave`

## Requirements
- R1: After reset the status register (address 2) reads 0b010: bit0 receive-ready is 0, bit1 transmit-ready is 1 and bit2 overrun is 0. The receive register (address 0) reads 0 and both interrupt outputs are low.
- R2: `spi_miso_oe` is high exactly while `spi_ss_n` is low.
- R3: When select falls, the word in the transmit holding register is copied into the shifter. Its most significant bit appears on miso, and each following bit appears after a falling sclk edge.
- R4: mosi is sampled on rising sclk edges, most significant bit first. When the last bit of a word is sampled, the word is copied to the receive register (address 0) and receive-ready (status bit0) is set.
- R5: A host read of address 0 clears receive-ready.
- R6: A host write to address 1 stores the transmit word and clears transmit-ready (status bit1). The falling edge of select that takes the word sets transmit-ready again.
- R7: If a word completes while receive-ready is still set, overrun (status bit2) is set and the new word replaces the old one. Writing address 2 with bit2 set clears overrun.
- R8: If select rises before a full word has been received, the partial word is discarded: receive-ready and the receive register do not change, and the next transfer starts from bit zero.
- R9: If the host writes no new transmit word before the next transfer, the last transmit word is sent again.
- R10: `irq_rx` equals receive-ready ANDed with control bit0, and `irq_tx` equals transmit-ready ANDed with control bit1. The control register is at address 3.
- R11: Extra sclk edges after a full word, and before select rises, are ignored. They complete no second word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | Register select: 0 receive, 1 transmit, 2 status, 3 control |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | DW | Host write data |
| host_rd | input | 1 | Host read strobe (needed for read side effects) |
| host_rdata | output | DW | Read data for `host_addr` (combinational) |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Active-low select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for an external miso buffer |

## Verification
Full words with mixed bit patterns run in both directions at once. A mismatch there shows bit-order and edge-choice errors on either path. Back-to-back words without a host read separate correct overrun and overwrite behaviour from a design that drops the word or fails to flag it, and a transfer with no new host write shows whether the last transmit word is held. Short transfers cut off by select, and transfers padded with extra sclk pulses, show whether the bit counter is framed by the select signal.

// File: rtl/spi_slv_pkg.sv
// Shared definitions for the SPI word slave.
// Assumes the host data width is at least 4 bits, so the status fields fit.
package spi_slv_pkg;
    typedef enum logic [1:0] {
        REG_RX   = 2'd0,
        REG_TX   = 2'd1,
        REG_STAT = 2'd2,
        REG_CTRL = 2'd3
    } reg_addr_e;

    localparam int STAT_RRDY = 0;
    localparam int STAT_TRDY = 1;
    localparam int STAT_ROE  = 2;
    localparam int CTRL_RXIE = 0;
    localparam int CTRL_TXIE = 1;
endpackage

// File: rtl/spi_in_sync.sv
// Brings sclk, select and mosi into the system clock through a flop chain.
// Reports sclk edges and the start of a select.
// Assumes clk runs at least 4x faster than sclk.
module spi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic ss_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sel_start,
    output logic sel_active,
    output logic mosi_s
);
    localparam logic [2:0] RST_V = 3'b010;   // {mosi, ss_n, sclk} idle values

    logic [2:0] raw;
    logic [2:0] synced;
    logic       sclk_prev;
    logic       ss_prev;

    assign raw = {mosi, ss_n, sclk};

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [2:0] q;
            if (g == 0) begin : g_first
                // First capture stage of the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) q <= RST_V;
                    else        q <= raw;
                end
            end else begin : g_next
                // Later stages: settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) q <= RST_V;
                    else        q <= g_stage[g-1].q;
                end
            end
        end
    endgenerate

    assign synced = g_stage[STAGES-1].q;

    // Keep the previous synchronized sclk and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            ss_prev   <= 1'b1;
        end else begin
            sclk_prev <= synced[0];
            ss_prev   <= synced[1];
        end
    end

    assign sclk_rise  = synced[0] & ~sclk_prev;
    assign sclk_fall  = ~synced[0] & sclk_prev;
    assign sel_active = ~synced[1];
    assign sel_start  = ss_prev & ~synced[1];
    assign mosi_s     = synced[2];
endmodule

// File: rtl/spi_shift_core.sv
// Shift registers for one word per select, SPI mode 0, MSB first.
// Loads the transmit word when select starts. Signals the last bit with a
// one-cycle pulse and the completed word. Drops partial words when select
// ends, and ignores edges after the word is complete.
module spi_shift_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          sel_start,
    input  logic          sel_active,
    input  logic          mosi_s,
    input  logic [DW-1:0] tx_word,
    output logic          miso_bit,
    output logic          word_done,
    output logic [DW-1:0] rx_next
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    logic [DW-1:0] tx_sr;
    logic [DW-1:0] rx_sr;
    logic [CW-1:0] bit_cnt;
    logic          locked;

    assign rx_next   = {rx_sr[DW-2:0], mosi_s};
    assign word_done = sel_active & ~sel_start & ~locked & sclk_rise & (bit_cnt == LAST);
    assign miso_bit  = tx_sr[DW-1];

    // Frame control: clear on select start or end, count rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            locked  <= 1'b0;
        end else if (sel_start || !sel_active) begin
            bit_cnt <= '0;
            locked  <= 1'b0;
        end else if (sclk_rise && !locked) begin
            if (bit_cnt == LAST) begin
                bit_cnt <= '0;
                locked  <= 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Receive shifter: sample mosi on rising sclk.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       rx_sr <= '0;
        else if (sel_start)                               rx_sr <= '0;
        else if (sel_active && sclk_rise && !locked)      rx_sr <= rx_next;
    end

    // Transmit shifter: load at select start, advance on falling sclk.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       tx_sr <= '0;
        else if (sel_start)                               tx_sr <= tx_word;
        else if (sel_active && sclk_fall && !locked)      tx_sr <= {tx_sr[DW-2:0], 1'b0};
    end
endmodule

// File: rtl/spi_host_regs.sv
// Host-side register file: receive, transmit, status and control.
// Read data is combinational. A read of the receive register clears the
// receive-ready flag on the clock edge where the read strobe is high.
module spi_host_regs
    import spi_slv_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    input  logic          word_done,
    input  logic [DW-1:0] rx_next,
    input  logic          sel_start,
    output logic [DW-1:0] tx_word,
    output logic [DW-1:0] rx_data,
    output logic          rrdy,
    output logic          trdy,
    output logic          roe,
    output logic          irq_rx,
    output logic          irq_tx
);
    logic [1:0] ctrl;
    logic       rx_rd;
    logic       tx_wr;
    logic       roe_clr;

    assign rx_rd   = rd & (addr == REG_RX);
    assign tx_wr   = wr & (addr == REG_TX);
    assign roe_clr = wr & (addr == REG_STAT) & wdata[STAT_ROE];

    // Receive register and flags, updated by completed words and host reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rrdy    <= 1'b0;
            roe     <= 1'b0;
        end else begin
            if (word_done) rx_data <= rx_next;
            if (word_done)  rrdy <= 1'b1;
            else if (rx_rd) rrdy <= 1'b0;
            if (word_done && rrdy && !rx_rd) roe <= 1'b1;
            else if (roe_clr)                roe <= 1'b0;
        end
    end

    // Transmit holding register and its ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word <= '0;
            trdy    <= 1'b1;
        end else begin
            if (tx_wr) tx_word <= wdata;
            if (tx_wr)          trdy <= 1'b0;
            else if (sel_start) trdy <= 1'b1;
        end
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ctrl <= '0;
        else if (wr && addr == REG_CTRL)    ctrl <= wdata[1:0];
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_RX:   rdata = rx_data;
            REG_TX:   rdata = tx_word;
            REG_STAT: begin
                rdata[STAT_RRDY] = rrdy;
                rdata[STAT_TRDY] = trdy;
                rdata[STAT_ROE]  = roe;
            end
            REG_CTRL: rdata[1:0] = ctrl;
            default:  rdata = '0;
        endcase
    end

    assign irq_rx = rrdy & ctrl[CTRL_RXIE];
    assign irq_tx = trdy & ctrl[CTRL_TXIE];
endmodule

// File: rtl/spi_word_slave.sv
// Top level: SPI mode 0 slave, one word per select, with host registers.
// miso_oe follows the raw select pin so an external buffer releases the line
// at once when select is high.
module spi_word_slave #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    host_addr,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    output logic          irq_rx,
    output logic          irq_tx,
    input  logic          spi_sclk,
    input  logic          spi_ss_n,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic          spi_miso_oe
);
    logic          sclk_rise;
    logic          sclk_fall;
    logic          sel_start;
    logic          sel_active;
    logic          mosi_s;
    logic          word_done;
    logic [DW-1:0] rx_next;
    logic [DW-1:0] tx_word;
    logic [DW-1:0] rx_data;
    logic          rrdy;
    logic          trdy;
    logic          roe;

    spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sclk(spi_sclk), .ss_n(spi_ss_n), .mosi(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sel_start(sel_start), .sel_active(sel_active), .mosi_s(mosi_s)
    );

    spi_shift_core #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .sel_start(sel_start), .sel_active(sel_active), .mosi_s(mosi_s),
        .tx_word(tx_word), .miso_bit(spi_miso),
        .word_done(word_done), .rx_next(rx_next)
    );

    spi_host_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr(host_addr), .wr(host_wr), .wdata(host_wdata),
        .rd(host_rd), .rdata(host_rdata),
        .word_done(word_done), .rx_next(rx_next), .sel_start(sel_start),
        .tx_word(tx_word), .rx_data(rx_data),
        .rrdy(rrdy), .trdy(trdy), .roe(roe),
        .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    assign spi_miso_oe = ~spi_ss_n;
endmodule

// File: rtl/spi_word_slave_chk.sv
// Protocol checker for spi_word_slave. It watches the host strobes and the
// internal flags, and is attached to every instance of the top by bind.
module spi_word_slave_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    host_addr,
    input logic          host_wr,
    input logic          host_rd,
    input logic          word_done,
    input logic          sel_start,
    input logic          rrdy,
    input logic          trdy,
    input logic          roe,
    input logic [DW-1:0] rx_data
);
    // R4: the receive register only moves when a word completes.
    p_rx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !word_done |=> $stable(rx_data));

    // R4: a completed word raises receive-ready.
    p_rrdy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> rrdy);

    // R5: reading the receive register clears ready unless a word lands.
    p_rrdy_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == 2'd0 && !word_done) |=> !rrdy);

    // R6: a transmit write clears transmit-ready.
    p_trdy_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 2'd1) |=> !trdy);

    // R6: select start without a write sets transmit-ready.
    p_trdy_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_start && !(host_wr && host_addr == 2'd1)) |=> trdy);

    // R7: a word landing on an unread word flags overrun.
    p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && rrdy && !(host_rd && host_addr == 2'd0)) |=> roe);
endmodule

bind spi_word_slave spi_word_slave_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .word_done(word_done), .sel_start(sel_start),
    .rrdy(rrdy), .trdy(trdy), .roe(roe), .rx_data(rx_data)
);

// File: tb/sim_spi_word_slave.sv
// Directed bench for spi_word_slave: one task per scenario.
module sim_spi_word_slave;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    host_addr = '0;
    logic          host_wr = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_rd = 1'b0;
    logic [DW-1:0] host_rdata;
    logic          irq_rx, irq_tx;
    logic          spi_sclk = 1'b0;
    logic          spi_ss_n = 1'b1;
    logic          spi_mosi = 1'b0;
    logic          spi_miso, spi_miso_oe;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    spi_word_slave #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .irq_rx(irq_rx), .irq_tx(irq_tx),
        .spi_sclk(spi_sclk), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // Peek without the read strobe (no side effects).
    task automatic hpeek(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    // Master transfer: nbits rising edges, the first DW bits taken from m_out.
    task automatic spi_xfer(input logic [DW-1:0] m_out, input int nbits,
                            output logic [DW-1:0] m_in);
        m_in = '0;
        @(negedge clk);
        spi_ss_n = 1'b0;
        #1 chk("R2", "oe while selected", spi_miso_oe, 1'b1);
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < DW) ? m_out[DW-1-i] : 1'b0;
            repeat (4) @(negedge clk);
            if (i < DW) m_in[DW-1-i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (6) @(negedge clk);
            spi_sclk = 1'b0;
            repeat (6) @(negedge clk);
        end
        spi_ss_n = 1'b1;
        #1 chk("R2", "oe after deselect", spi_miso_oe, 1'b0);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        hpeek(2'd2, d); chk("R1", "status after reset", d, 8'h02);
        hpeek(2'd0, d); chk("R1", "rx after reset", d, 8'h00);
        chk("R1", "irq_rx after reset", irq_rx, 1'b0);
        chk("R1", "irq_tx after reset", irq_tx, 1'b0);
        chk("R2", "oe idle", spi_miso_oe, 1'b0);
    endtask

    task automatic t_basic();
        logic [DW-1:0] d, got;
        hwrite(2'd1, 8'hA5);
        hpeek(2'd2, d); chk("R6", "trdy cleared by write", d[1], 1'b0);
        spi_xfer(8'h3C, DW, got);
        chk("R3", "miso word MSB first", got, 8'hA5);
        hpeek(2'd2, d); chk("R4", "rrdy/trdy after word", d, 8'h03);
        hread(2'd0, d); chk("R4", "rx word", d, 8'h3C);
        hpeek(2'd2, d); chk("R5", "rrdy cleared by read", d[0], 1'b0);
    endtask

    task automatic t_resend();
        logic [DW-1:0] d, got;
        spi_xfer(8'h81, DW, got);
        chk("R9", "last tx word resent", got, 8'hA5);
        hread(2'd0, d); chk("R4", "rx word 81", d, 8'h81);
    endtask

    task automatic t_overrun();
        logic [DW-1:0] d, got;
        hwrite(2'd1, 8'h5A);
        spi_xfer(8'h11, DW, got);
        chk("R3", "miso word 5A", got, 8'h5A);
        hpeek(2'd2, d); chk("R7", "no overrun on first word", d[2], 1'b0);
        spi_xfer(8'h22, DW, got);
        hpeek(2'd2, d); chk("R7", "overrun flagged", d[2], 1'b1);
        hpeek(2'd0, d); chk("R7", "new word overwrites", d, 8'h22);
        hwrite(2'd2, 8'h04);
        hpeek(2'd2, d); chk("R7", "overrun cleared", d[2], 1'b0);
        hread(2'd0, d);
    endtask

    task automatic t_partial();
        logic [DW-1:0] d, got;
        spi_xfer(8'hFF, 3, got);
        hpeek(2'd2, d); chk("R8", "no rrdy after partial", d[0], 1'b0);
        hpeek(2'd0, d); chk("R8", "rx unchanged after partial", d, 8'h22);
        spi_xfer(8'h96, DW, got);
        hpeek(2'd0, d); chk("R8", "fresh word after partial", d, 8'h96);
    endtask

    task automatic t_irq();
        logic [DW-1:0] d;
        chk("R10", "irq_rx masked", irq_rx, 1'b0);
        hwrite(2'd3, 8'h03);
        #1 chk("R10", "irq_rx enabled", irq_rx, 1'b1);
        chk("R10", "irq_tx enabled", irq_tx, 1'b1);
        hread(2'd0, d);
        #1 chk("R10", "irq_rx after read", irq_rx, 1'b0);
        hwrite(2'd1, 8'hC3);
        #1 chk("R10", "irq_tx after write", irq_tx, 1'b0);
        hwrite(2'd3, 8'h00);
    endtask

    task automatic t_extra();
        logic [DW-1:0] d, got;
        spi_xfer(8'h6D, DW + 3, got);
        chk("R3", "miso word C3", got, 8'hC3);
        hpeek(2'd0, d); chk("R11", "word kept with extra edges", d, 8'h6D);
        hpeek(2'd2, d); chk("R11", "no second word (no overrun)", d[2], 1'b0);
        hread(2'd0, d);
        spi_xfer(8'h00, DW, got);
        hpeek(2'd0, d); chk("R11", "next word frames cleanly", d, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_resend();
        t_overrun();
        t_partial();
        t_irq();
        t_extra();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule